// File: doc/BRIEF.md
# Paged RAM chunk address mapper

This block steers every CPU access that targets the board's single 512K x 8 static RAM. The RAM is treated as 32 chunks of 16 KB. The block decides which chunk, if any, answers the current CPU address and drives the RAM address, chip enable and write enable. The RAM address is always the 5-bit chunk number on top of CPU address bits 13:0. The chunk is chosen from several sources:

- the 4-bit sideways bank register, for the 16 KB paged window;
- the shadow and private RAM requests;
- an extended-bank select, for paged images that are longer than 16 KB.

Chunks 16 to 31 are normally reachable only through their dedicated functions. A long press of the BREAK key enters a recovery mode. In that mode, the paged window reaches any of the 32 chunks through the bank register plus one extra high bit. A short press of BREAK leaves recovery mode, and so does reset.

When several requests are present at once, a fixed priority grants one of them. The internal chunk-select vector is therefore never more than one-hot. The mapping logic is combinational from the inputs and the recovery flag. Only the long-press detector holds state.

Top module: `pgram_chunk_map`

## Requirements
- R1: Whenever `ram_ce` is 1, `ram_addr` equals {chunk[4:0], cpu_addr[13:0]}.
- R2: In normal mode, an access to the paged window (cpu_addr 0x8000-0xBFFF) that no higher-priority source claims maps to the chunk equal to `bank_sel`. Chunks 18 and 19 are never selected in normal mode.
- R3: With `shadow_req` high, addresses 0x4000-0x7FFF map to chunk 16 and addresses 0x3000-0x3FFF map to chunk 17. With `shadow_req` low, addresses 0x3000-0x7FFF leave `ram_ce` low.
- R4: With `private_req` high, addresses 0x8000-0xAFFF map to chunk 17. Addresses 0xB000-0xBFFF are unaffected by `private_req`.
- R5: With `ximg_req` high in the paged window, the image kind and the bank index select a chunk as follows:
  - kind 0 with index 1 selects chunk 20;
  - kind 1 with index 1 selects chunk 21;
  - kind 2 with index 1-3 selects chunks 22-24;
  - kind 3 with index 1-7 selects chunks 25-31.
  Index 0, or an index beyond the image, is ignored and the sideways bank applies.
- R6: When both the private window and an extended-bank select match, private RAM wins.
- R7: Recovery mode is entered once BREAK has been held for LONG_PRESS_CYCLES consecutive rising clock edges. A press that is one edge shorter leaves the mode unchanged.
- R8: In recovery mode, the paged window maps to chunk {bank_hi, bank_sel}, so all 32 chunks are reachable. This overrides private RAM and extended selects. Shadow mapping outside the paged window is unchanged.
- R9: In recovery mode, a BREAK press released before LONG_PRESS_CYCLES edges ends recovery mode. A further long press keeps recovery mode. Reset ends recovery mode.
- R10: `ram_ce` is 0 in the following cases, and `ram_we` equals `ram_ce` AND NOT `cpu_rnw`:
  - for cpu_addr below 0x3000;
  - for cpu_addr 0xC000 and above;
  - for unclaimed shadow addresses.
- R11: At most one bit of the internal 32-bit chunk-select vector is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| bank_sel | input | 4 | Sideways bank register |
| bank_hi | input | 1 | Extra high chunk bit, used in recovery mode |
| shadow_req | input | 1 | Shadow RAM access request |
| private_req | input | 1 | Private RAM access request |
| ximg_req | input | 1 | Extended paged-image bank request |
| ximg_kind | input | 2 | Image kind: 0/1 = 32 KB images, 2 = 64 KB, 3 = 128 KB |
| ximg_idx | input | 3 | Bank index inside the image (1 = second bank) |
| brk_key | input | 1 | BREAK key, 1 = pressed, synchronous to clk |
| ram_addr | output | 19 | RAM address {chunk, cpu_addr[13:0]} |
| ram_ce | output | 1 | RAM chip enable, active high |
| ram_we | output | 1 | RAM write enable, active high |

## Verification
The hardest state to reach from the ports is recovery mode, and in particular the exact press length at which it switches. The stimulus holds BREAK for one edge fewer than the threshold and then for exactly the threshold, with the threshold shortened to 16 in the bench. It then checks the effect only through the mapping: bank_hi with bank 2 reaches chunk 18.

Leaving the mode needs a short press while in recovery, and staying in it needs a second long press; both are driven directly. Random accesses are then run in both modes, with every request line toggling at once. This exercises the priority between simultaneous requests.

// File: rtl/pgram_pkg.sv
package pgram_pkg;

    localparam int CHUNK_W    = 5;
    localparam int NUM_CHUNKS = 1 << CHUNK_W;
    localparam int OFS_W      = 14;
    localparam int CPU_AW     = 16;
    localparam int BANK_W     = CHUNK_W - 1;
    localparam int XIDX_W     = 3;
    localparam int NUM_SRC    = 4;
    localparam int RAM_AW     = CHUNK_W + OFS_W;

    // source positions, lower index wins
    localparam int SRC_RECOV  = 0;
    localparam int SRC_SHPRIV = 1;
    localparam int SRC_XIMG   = 2;
    localparam int SRC_SWBANK = 3;

    typedef logic [CHUNK_W-1:0] chunk_t;

    typedef struct packed {
        logic   vld;
        chunk_t num;
    } chunk_req_t;

    typedef enum logic [1:0] {
        IMG_DUO_A = 2'd0,
        IMG_DUO_B = 2'd1,
        IMG_QUAD  = 2'd2,
        IMG_OCT   = 2'd3
    } img_e;

    localparam chunk_t CH_SHADOW_MAIN = chunk_t'(16);
    localparam chunk_t CH_SHARED      = chunk_t'(17);

    // first chunk holding bank index 1 of each image kind
    function automatic chunk_t img_base(img_e kind);
        case (kind)
            IMG_DUO_A: return chunk_t'(20);
            IMG_DUO_B: return chunk_t'(21);
            IMG_QUAD:  return chunk_t'(22);
            default:   return chunk_t'(25);
        endcase
    endfunction

    // number of banks in each image, bank 0 lives in the sideways area
    function automatic logic [XIDX_W:0] img_span(img_e kind);
        case (kind)
            IMG_DUO_A, IMG_DUO_B: return 4'd2;
            IMG_QUAD:             return 4'd4;
            default:              return 4'd8;
        endcase
    endfunction

    function automatic chunk_req_t ximg_lookup(img_e kind, logic [XIDX_W-1:0] idx);
        chunk_req_t r;
        r.vld = (idx != '0) && ({1'b0, idx} < img_span(kind));
        r.num = img_base(kind) + chunk_t'(idx) - chunk_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/pgram_break_timer.sv
module pgram_break_timer #(
    parameter int LONG_PRESS_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic brk_held,
    output logic rec_mode
);
    localparam int CNT_W = $clog2(LONG_PRESS_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(LONG_PRESS_CYCLES);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(LONG_PRESS_CYCLES - 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             short_release;

    assign short_release = (hold_cnt != '0) && (hold_cnt < LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            rec_mode <= 1'b0;
        end else if (brk_held) begin
            if (hold_cnt != LIMIT) begin
                hold_cnt <= hold_cnt + 1'b1;
            end
            if (hold_cnt == LIMIT_M1) begin
                rec_mode <= 1'b1;
            end
        end else begin
            if (rec_mode && short_release) begin
                rec_mode <= 1'b0;
            end
            hold_cnt <= '0;
        end
    end
endmodule

// File: rtl/pgram_req_decode.sv
module pgram_req_decode
    import pgram_pkg::*;
(
    input  logic                        rec_mode,
    input  logic [3:0]                  win_nib,
    input  logic [BANK_W-1:0]           bank_sel,
    input  logic                        bank_hi,
    input  logic                        shadow_req,
    input  logic                        private_req,
    input  logic                        ximg_req,
    input  logic [1:0]                  ximg_kind,
    input  logic [XIDX_W-1:0]           ximg_idx,
    output chunk_req_t [NUM_SRC-1:0]    reqs
);
    logic       in_paged;
    logic       in_priv;
    logic       in_shadow;
    chunk_req_t ximg_hit;

    assign in_paged  = (win_nib[3:2] == 2'b10);
    assign in_priv   = in_paged && (win_nib != 4'hB);
    assign in_shadow = (win_nib >= 4'h3) && (win_nib <= 4'h7);
    assign ximg_hit  = ximg_lookup(img_e'(ximg_kind), ximg_idx);

    always_comb begin
        reqs = '0;

        reqs[SRC_RECOV].vld = rec_mode && in_paged;
        reqs[SRC_RECOV].num = {bank_hi, bank_sel};

        if (shadow_req && in_shadow) begin
            reqs[SRC_SHPRIV].vld = 1'b1;
            reqs[SRC_SHPRIV].num = (win_nib == 4'h3) ? CH_SHARED : CH_SHADOW_MAIN;
        end else if (private_req && in_priv) begin
            reqs[SRC_SHPRIV].vld = 1'b1;
            reqs[SRC_SHPRIV].num = CH_SHARED;
        end

        reqs[SRC_XIMG].vld = ximg_req && in_paged && ximg_hit.vld;
        reqs[SRC_XIMG].num = ximg_hit.num;

        reqs[SRC_SWBANK].vld = in_paged;
        reqs[SRC_SWBANK].num = {1'b0, bank_sel};
    end
endmodule

// File: rtl/pgram_prio_sel.sv
module pgram_prio_sel
    import pgram_pkg::*;
(
    input  chunk_req_t [NUM_SRC-1:0]  reqs,
    output logic [NUM_CHUNKS-1:0]     sel_vec
);
    logic [NUM_SRC:0]   blocked;
    logic [NUM_SRC-1:0] grant;
    chunk_t             win_num;
    logic               any_grant;

    assign blocked[0] = 1'b0;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_grant
        assign grant[s]     = reqs[s].vld && !blocked[s];
        assign blocked[s+1] = blocked[s] || reqs[s].vld;
    end

    always_comb begin
        win_num = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (grant[s]) begin
                win_num = win_num | reqs[s].num;
            end
        end
    end

    assign any_grant = |grant;

    for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_sel
        assign sel_vec[c] = any_grant && (win_num == chunk_t'(c));
    end
endmodule

// File: rtl/pgram_chunk_map.sv
module pgram_chunk_map
    import pgram_pkg::*;
#(
    parameter int LONG_PRESS_CYCLES = 2_000_000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic                 cpu_rnw,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic                 bank_hi,
    input  logic                 shadow_req,
    input  logic                 private_req,
    input  logic                 ximg_req,
    input  logic [1:0]           ximg_kind,
    input  logic [XIDX_W-1:0]    ximg_idx,
    input  logic                 brk_key,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic                 ram_ce,
    output logic                 ram_we
);
    logic                      rec_mode;
    chunk_req_t [NUM_SRC-1:0]  reqs;
    logic [NUM_CHUNKS-1:0]     sel_vec;
    chunk_t                    chunk_enc;

    pgram_break_timer #(
        .LONG_PRESS_CYCLES (LONG_PRESS_CYCLES)
    ) i_break_timer (
        .clk      (clk),
        .rst      (rst),
        .brk_held (brk_key),
        .rec_mode (rec_mode)
    );

    pgram_req_decode i_req_decode (
        .rec_mode    (rec_mode),
        .win_nib     (cpu_addr[CPU_AW-1:CPU_AW-4]),
        .bank_sel    (bank_sel),
        .bank_hi     (bank_hi),
        .shadow_req  (shadow_req),
        .private_req (private_req),
        .ximg_req    (ximg_req),
        .ximg_kind   (ximg_kind),
        .ximg_idx    (ximg_idx),
        .reqs        (reqs)
    );

    pgram_prio_sel i_prio_sel (
        .reqs    (reqs),
        .sel_vec (sel_vec)
    );

    // one-hot to binary, by OR of the indices of set bits
    always_comb begin
        chunk_enc = '0;
        for (int c = 0; c < NUM_CHUNKS; c++) begin
            if (sel_vec[c]) begin
                chunk_enc = chunk_enc | chunk_t'(c);
            end
        end
    end

    assign ram_addr = {chunk_enc, cpu_addr[OFS_W-1:0]};
    assign ram_ce   = |sel_vec;
    assign ram_we   = ram_ce && !cpu_rnw;
endmodule

// File: rtl/pgram_chunk_map_chk.sv
module pgram_chunk_map_chk
    import pgram_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [CPU_AW-1:0]     cpu_addr,
    input logic                  cpu_rnw,
    input logic                  shadow_req,
    input logic                  brk_key,
    input logic [RAM_AW-1:0]     ram_addr,
    input logic                  ram_ce,
    input logic                  ram_we,
    input logic                  rec_mode,
    input logic [NUM_CHUNKS-1:0] sel_vec
);
    // R11
    one_chunk_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_vec));

    // R7
    rec_enter_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_mode) |-> $past(brk_key));

    // R9
    rec_leave_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rec_mode) |-> !$past(brk_key));

    // R10
    upper_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b11) |-> !ram_ce);

    // R10
    write_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_ce && !cpu_rnw));

    // R3
    shadow_map_chk: assert property (@(posedge clk) disable iff (rst)
        (shadow_req && cpu_addr[15:14] == 2'b01)
            |-> (ram_ce && ram_addr[RAM_AW-1:OFS_W] == CH_SHADOW_MAIN));

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        ram_ce |-> (ram_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]));
endmodule

bind pgram_chunk_map pgram_chunk_map_chk i_chunk_map_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_rnw    (cpu_rnw),
    .shadow_req (shadow_req),
    .brk_key    (brk_key),
    .ram_addr   (ram_addr),
    .ram_ce     (ram_ce),
    .ram_we     (ram_we),
    .rec_mode   (rec_mode),
    .sel_vec    (sel_vec)
);

// File: tb/test_pgram_chunk_map.sv
module test_pgram_chunk_map;
    localparam int CLK_PERIOD = 10;
    localparam int LP         = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic [3:0]  bank_sel = '0;
    logic        bank_hi = 1'b0;
    logic        shadow_req = 1'b0;
    logic        private_req = 1'b0;
    logic        ximg_req = 1'b0;
    logic [1:0]  ximg_kind = '0;
    logic [2:0]  ximg_idx = '0;
    logic        brk_key = 1'b0;
    logic [18:0] ram_addr;
    logic        ram_ce;
    logic        ram_we;

    int n_chk  = 0;
    int n_fail = 0;
    bit model_rec = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgram_chunk_map #(.LONG_PRESS_CYCLES(LP)) i_pgram_chunk_map (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
        .bank_sel(bank_sel), .bank_hi(bank_hi), .shadow_req(shadow_req),
        .private_req(private_req), .ximg_req(ximg_req), .ximg_kind(ximg_kind),
        .ximg_idx(ximg_idx), .brk_key(brk_key), .ram_addr(ram_addr),
        .ram_ce(ram_ce), .ram_we(ram_we));

    // expected {ce, chunk} from the requirements
    function automatic logic [5:0] expect_map(logic [15:0] a, logic rec, logic [3:0] bk,
            logic hi, logic sh, logic pr, logic xr, logic [1:0] xk, logic [2:0] xi);
        logic [3:0] nib = a[15:12];
        bit paged = (nib >= 4'h8) && (nib <= 4'hB);
        if (rec && paged) return {1'b1, hi, bk};
        if (sh && nib >= 4'h3 && nib <= 4'h7) return (nib == 4'h3) ? 6'h31 : 6'h30;
        if (pr && nib >= 4'h8 && nib <= 4'hA) return 6'h31;
        if (paged) begin
            if (xr) begin
                if (xk == 2'd0 && xi == 3'd1) return 6'h34;
                if (xk == 2'd1 && xi == 3'd1) return 6'h35;
                if (xk == 2'd2 && xi >= 3'd1 && xi <= 3'd3) return 6'h20 | (6'd21 + xi);
                if (xk == 2'd3 && xi >= 3'd1) return 6'h20 | (6'd24 + xi);
            end
            return {2'b10, bk};
        end
        return 6'h00;
    endfunction

    task automatic apply(input logic [15:0] a, input logic rnw, input logic [3:0] bk,
            input logic hi, input logic sh, input logic pr, input logic xr,
            input logic [1:0] xk, input logic [2:0] xi);
        @(negedge clk);
        cpu_addr = a; cpu_rnw = rnw; bank_sel = bk; bank_hi = hi;
        shadow_req = sh; private_req = pr; ximg_req = xr; ximg_kind = xk; ximg_idx = xi;
        #1;
    endtask

    task automatic check(input string req);
        logic [5:0] e;
        logic       ewe;
        e = expect_map(cpu_addr, model_rec, bank_sel, bank_hi, shadow_req, private_req,
                       ximg_req, ximg_kind, ximg_idx);
        ewe = e[5] && !cpu_rnw;
        n_chk++;
        if (ram_ce !== e[5] || ram_we !== ewe ||
            (e[5] && ram_addr !== {e[4:0], cpu_addr[13:0]})) begin
            n_fail++;
            $display("FAIL %s addr=%h: got ce=%b we=%b ram_addr=%h, expected ce=%b we=%b ram_addr=%h",
                     req, cpu_addr, ram_ce, ram_we, ram_addr, e[5], ewe,
                     {e[4:0], cpu_addr[13:0]});
        end
    endtask

    task automatic press(input int n);
        @(negedge clk);
        brk_key = 1'b1;
        repeat (n) @(negedge clk);
        brk_key = 1'b0;
    endtask

    task automatic go(input string req, input logic [15:0] a, input logic rnw,
            input logic [3:0] bk, input logic hi, input logic sh, input logic pr,
            input logic xr, input logic [1:0] xk, input logic [2:0] xi);
        apply(a, rnw, bk, hi, sh, pr, xr, xk, xi);
        check(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state: normal mode, R2 bank select, hi bit ignored
        go("R2", 16'h8000, 1, 4'd5, 0, 0, 0, 0, 0, 0);
        go("R2", 16'h8abc, 1, 4'd2, 1, 0, 0, 0, 0, 0);
        // R3 shadow
        go("R3", 16'h3000, 1, 4'd0, 0, 1, 0, 0, 0, 0);
        go("R3", 16'h7fff, 0, 4'd0, 0, 1, 0, 0, 0, 0);
        go("R3", 16'h5000, 1, 4'd0, 0, 0, 0, 0, 0, 0);
        // R4 private
        go("R4", 16'h8123, 0, 4'd3, 0, 0, 1, 0, 0, 0);
        go("R4", 16'hb000, 1, 4'd3, 0, 0, 1, 0, 0, 0);
        // R5 extended images
        go("R5", 16'h9000, 1, 4'd1, 0, 0, 0, 1, 2'd0, 3'd1);
        go("R5", 16'h9000, 1, 4'd1, 0, 0, 0, 1, 2'd1, 3'd1);
        go("R5", 16'ha000, 1, 4'd1, 0, 0, 0, 1, 2'd2, 3'd3);
        go("R5", 16'hbfff, 0, 4'd1, 0, 0, 0, 1, 2'd3, 3'd7);
        go("R5", 16'h9000, 1, 4'd6, 0, 0, 0, 1, 2'd3, 3'd0);
        go("R5", 16'h9000, 1, 4'd6, 0, 0, 0, 1, 2'd0, 3'd2);
        go("R5", 16'h9000, 1, 4'd6, 0, 0, 0, 1, 2'd2, 3'd4);
        // R6 priority private over extended
        go("R6", 16'h9000, 1, 4'd4, 0, 0, 1, 1, 2'd3, 3'd2);
        go("R6", 16'hb000, 1, 4'd4, 0, 0, 1, 1, 2'd3, 3'd2);
        // R10 windows and write gating
        go("R10", 16'hc000, 0, 4'd4, 0, 1, 1, 1, 2'd3, 3'd2);
        go("R10", 16'h2fff, 0, 4'd4, 0, 1, 1, 0, 0, 0);
        go("R10", 16'h8000, 0, 4'd9, 0, 0, 0, 0, 0, 0);

        // R7 one edge short: still normal
        press(LP - 1);
        go("R7", 16'h8000, 1, 4'd2, 1, 0, 0, 0, 0, 0);
        // R7 exact length: recovery
        press(LP);
        model_rec = 1'b1;
        go("R7", 16'h8000, 1, 4'd2, 1, 0, 0, 0, 0, 0);
        go("R8", 16'h8000, 0, 4'd3, 1, 0, 1, 1, 2'd3, 3'd1);
        go("R8", 16'h4000, 1, 4'd3, 1, 1, 0, 0, 0, 0);
        go("R8", 16'hbfff, 1, 4'hf, 1, 0, 0, 0, 0, 0);
        // R9 long press keeps recovery
        press(LP + 3);
        go("R9", 16'h8000, 1, 4'd3, 1, 0, 0, 0, 0, 0);
        // random in recovery mode
        for (int i = 0; i < 500; i++) begin
            apply(16'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 2'($urandom), 3'($urandom));
            check("R8");
        end
        // R9 short press leaves
        press(3);
        model_rec = 1'b0;
        go("R9", 16'h8000, 1, 4'd3, 1, 0, 0, 0, 0, 0);
        // R9 reset leaves
        press(LP);
        model_rec = 1'b1;
        go("R9", 16'h8000, 1, 4'd1, 1, 0, 0, 0, 0, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_rec = 1'b0;
        go("R9", 16'h8000, 1, 4'd1, 1, 0, 0, 0, 0, 0);
        // random in normal mode
        for (int i = 0; i < 800; i++) begin
            apply(16'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 2'($urandom), 3'($urandom));
            check("R1");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule